// File: doc/BRIEF.md
# Table-Driven Multi-Line Serial Transmit Scanner

This block drives sixteen asynchronous serial transmit lines while keeping almost no per-line state on chip. Each line's next-character pointer and remaining character count sit in two small tables in main memory. The block reaches those tables through a word-wide memory port. When a line is active and its serializer is idle, the scanner does the following in order:

1. It reads the line's pointer and count from the tables.
2. It fetches the character the pointer selects and hands it to the line's serializer.
3. It writes the advanced pointer and the reduced count back to memory.

When a line's count runs out, the scanner drops the line's active bit and raises a sticky transmit interrupt.

Software sets up the tables and sets active bits with a one-cycle pulse mask. The tables begin at a 256-byte-aligned base given by an 8-bit page input. The table layout is as follows:

- The pointer entry for line n is at byte address `{page, 8'h00} + 2n`. The line number therefore occupies address bits 4:1.
- The count entry for line n is at `{page, 8'h00} + 0x20 + 2n`.

Pointers are byte addresses. A fetch reads the 16-bit word at the pointer with bit 0 cleared. It takes the low byte (bits 7:0) for an even pointer and the high byte (bits 15:8) for an odd pointer.

The memory port is a request/acknowledge stream. `mem_req_o` plays the role of valid and `mem_ack_i` the role of ready. A transaction completes on a rising edge where both are high. Read data must be valid in that same cycle. The memory may hold off for any number of cycles by keeping `mem_ack_i` low. The block keeps its request and all request fields unchanged until the acknowledge arrives. It has at most one transaction in flight at any time.

All sixteen serializers share one framing setting: 5 to 8 data bits and 1 or 2 stop bits. Each line also has a break input that holds the line low.

Top module: `txs_scanner`

## Requirements
- R1: While reset is held, and on release from reset, all active bits are 0, every transmit line is high (idle), there is no memory request, and the interrupt is low.
- R2: A line's service reads its pointer entry at `{page,8'h00}+2n`, then its count entry at `{page,8'h00}+0x20+2n`, then the word at the pointer with bit 0 cleared. The character is bits 7:0 of that word for an even pointer and bits 15:8 for an odd pointer.
- R3: After the character fetch, the block writes pointer+1 to the pointer entry and then count−1 to the count entry, in that order.
- R4: When the write-back count is 0, the line's active bit clears and the interrupt sets. If a count of 0 is read, the same happens with no character fetch, no write and no character sent.
- R5: Lines are served round-robin. The search starts at the line after the last one served and wraps from 15 to 0. It skips lines whose active bit is clear or whose serializer is busy.
- R6: Only one memory request is outstanding at a time. While `mem_req_o` is high and `mem_ack_i` is low, the request and its address, write enable and write data stay unchanged.
- R7: Each character is sent as follows, and an idle line is high:
  - a low start bit;
  - 5+`char_len_i` data bits, least significant first (`char_len_i` 0..3 gives 5..8 bits), with unused upper bits dropped;
  - 1 stop bit, or 2 when `two_stop_i` is 1, both high;
  - every bit lasts BIT_CLKS cycles.
- R8: While `brk_i[n]` is high, line n is low, regardless of any activity on it.
- R9: Once set, the interrupt stays high until an `irq_clr_i` pulse clears it. A completion in the same cycle as a clear leaves it set.
- R10: An active bit becomes 1 only through a 1 in `act_set_i` in the cycle before. It is readable on `active_o` one cycle after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tab_base_i | input | 8 | Table page (address bits 15:8) |
| act_set_i | input | 16 | One-cycle pulse mask that sets active bits |
| active_o | output | 16 | Current active bits |
| char_len_i | input | 2 | Data bits per character minus 5 |
| two_stop_i | input | 1 | 1 selects two stop bits |
| brk_i | input | 16 | Per-line break (force low) |
| tx_line_o | output | 16 | Serial transmit lines |
| irq_o | output | 1 | Sticky transmit-done interrupt |
| irq_clr_i | input | 1 | Clears the interrupt |
| mem_req_o | output | 1 | Memory request (valid) |
| mem_we_o | output | 1 | 1 for write, 0 for read |
| mem_addr_o | output | 16 | Byte address (bit 0 is 0) |
| mem_wdata_o | output | 16 | Write data |
| mem_ack_i | input | 1 | Memory acknowledge (ready); completes the transaction |
| mem_rdata_i | input | 16 | Read data, valid with the acknowledge |

## Verification
Round-robin order and busy-skip (R5) only show once several lines compete for the scanner while memory stalls. The bench therefore activates four lines in a single pulse, one of them with a zero count. Its memory model withholds the acknowledge on a fixed irregular pattern, so requests are stretched while the service order is recorded. A cycle-level model follows the five-step service sequence and checks every address and written word. Receivers sampling each line at mid-bit rebuild the characters, including an odd starting pointer and a 6-bit, two-stop configuration.

// File: rtl/txs_pkg.sv
package txs_pkg;
  typedef enum logic [2:0] {
    ST_SCAN,
    ST_RD_PTR,
    ST_RD_CNT,
    ST_RD_CHAR,
    ST_WR_PTR,
    ST_WR_CNT
  } txs_state_e;

  // byte offset of the count table from the table page
  localparam int unsigned CNT_TAB_OFS = 32'h20;
  // widest character and longest stop field the serializers handle
  localparam int unsigned MAX_DATA_BITS = 8;
  localparam int unsigned MAX_STOP_BITS = 2;
endpackage

// File: rtl/txs_rr_pick.sv
module txs_rr_pick #(
  parameter int unsigned N  = 16,
  parameter int unsigned IW = 4
) (
  input  logic [N-1:0]  elig_i,
  input  logic [IW-1:0] start_i,
  output logic          found_o,
  output logic [IW-1:0] pick_o
);
  logic [IW-1:0] idx;

  // first eligible line at or after start_i, wrapping (N is a power of two)
  always_comb begin
    found_o = 1'b0;
    pick_o  = start_i;
    idx     = '0;
    for (int i = 0; i < N; i++) begin
      idx = start_i + IW'(i);
      if (!found_o && elig_i[idx]) begin
        found_o = 1'b1;
        pick_o  = idx;
      end
    end
  end
endmodule

// File: rtl/txs_serializer.sv
module txs_serializer import txs_pkg::*; #(
  parameter int unsigned BIT_CLKS = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_i,
  input  logic [MAX_DATA_BITS-1:0] data_i,
  input  logic [3:0]               nbits_i,
  input  logic                     two_stop_i,
  input  logic                     brk_i,
  output logic                     busy_o,
  output logic                     line_o
);
  localparam int unsigned FW    = 1 + MAX_DATA_BITS + MAX_STOP_BITS;
  localparam int unsigned CW    = $clog2(FW + 1);
  localparam int unsigned DIV_W = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;

  logic [FW-1:0]    frame, sr_q;
  logic [CW-1:0]    total, left_q;
  logic [DIV_W-1:0] div_q;

  // start bit at position 0, data above it, ones fill the stop field
  always_comb begin
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < MAX_DATA_BITS; i++)
      if (i < int'(nbits_i)) frame[i+1] = data_i[i];
    total = CW'(1) + CW'(nbits_i) + (two_stop_i ? CW'(2) : CW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '1;
      left_q <= '0;
      div_q  <= '0;
    end else if (load_i) begin
      sr_q   <= frame;
      left_q <= total;
      div_q  <= DIV_W'(BIT_CLKS - 1);
    end else if (left_q != '0) begin
      if (div_q == '0) begin
        div_q  <= DIV_W'(BIT_CLKS - 1);
        sr_q   <= {1'b1, sr_q[FW-1:1]};
        left_q <= left_q - CW'(1);
      end else begin
        div_q <= div_q - DIV_W'(1);
      end
    end
  end

  assign busy_o = (left_q != '0);
  assign line_o = !brk_i && (busy_o ? sr_q[0] : 1'b1);
endmodule

// File: rtl/txs_scanner.sv
module txs_scanner import txs_pkg::*; #(
  parameter int unsigned LINES    = 16,
  parameter int unsigned AW       = 16,
  parameter int unsigned DW       = 16,
  parameter int unsigned BASE_W   = 8,
  parameter int unsigned BIT_CLKS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BASE_W-1:0] tab_base_i,
  input  logic [LINES-1:0]  act_set_i,
  output logic [LINES-1:0]  active_o,
  input  logic [1:0]        char_len_i,
  input  logic              two_stop_i,
  input  logic [LINES-1:0]  brk_i,
  output logic [LINES-1:0]  tx_line_o,
  output logic              irq_o,
  input  logic              irq_clr_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DW-1:0]     mem_rdata_i
);
  localparam int unsigned LW    = $clog2(LINES);
  localparam int unsigned OFS_W = AW - BASE_W;

  txs_state_e        st_q;
  logic [LW-1:0]     line_q, rr_q, pick;
  logic [BASE_W-1:0] base_q;
  logic [DW-1:0]     ptr_q, cnt_q;
  logic [LINES-1:0]  active_q, busy, elig, load_vec, clr_vec;
  logic              irq_q, found, hs, done;
  logic [AW-1:0]     row_addr;
  logic [MAX_DATA_BITS-1:0] char_byte;
  logic [3:0]        nbits;

  assign elig = active_q & ~busy;

  txs_rr_pick #(.N(LINES), .IW(LW)) u_pick (
    .elig_i (elig),
    .start_i(rr_q),
    .found_o(found),
    .pick_o (pick)
  );

  // ---------------- memory request fields (all from registers) ----------
  assign mem_req_o = (st_q != ST_SCAN);
  assign mem_we_o  = (st_q == ST_WR_PTR) || (st_q == ST_WR_CNT);
  assign hs        = mem_req_o && mem_ack_i;
  assign row_addr  = {base_q, OFS_W'(0)} | AW'({line_q, 1'b0});

  always_comb begin
    mem_addr_o  = row_addr;
    mem_wdata_o = '0;
    case (st_q)
      ST_RD_CNT:  mem_addr_o = row_addr | AW'(CNT_TAB_OFS);
      ST_RD_CHAR: mem_addr_o = {ptr_q[AW-1:1], 1'b0};
      ST_WR_PTR:  mem_wdata_o = ptr_q + DW'(1);
      ST_WR_CNT: begin
        mem_addr_o  = row_addr | AW'(CNT_TAB_OFS);
        mem_wdata_o = cnt_q - DW'(1);
      end
      default: ;
    endcase
  end

  // ---------------- completion, character hand-off ----------------------
  assign done = hs && (((st_q == ST_RD_CNT) && (mem_rdata_i == '0)) ||
                       ((st_q == ST_WR_CNT) && (cnt_q == DW'(1))));
  assign clr_vec   = done ? (LINES'(1) << line_q) : '0;
  assign load_vec  = (hs && (st_q == ST_RD_CHAR)) ? (LINES'(1) << line_q) : '0;
  assign char_byte = ptr_q[0] ? mem_rdata_i[15:8] : mem_rdata_i[7:0];
  assign nbits     = 4'd5 + {2'b00, char_len_i};

  // ---------------- service sequencer ------------------------------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_SCAN;
      line_q <= '0;
      rr_q   <= '0;
      base_q <= '0;
      ptr_q  <= '0;
      cnt_q  <= '0;
    end else begin
      case (st_q)
        ST_SCAN: if (found) begin
          line_q <= pick;
          base_q <= tab_base_i;
          st_q   <= ST_RD_PTR;
        end
        ST_RD_PTR: if (hs) begin
          ptr_q <= mem_rdata_i;
          st_q  <= ST_RD_CNT;
        end
        ST_RD_CNT: if (hs) begin
          cnt_q <= mem_rdata_i;
          if (mem_rdata_i == '0) begin
            st_q <= ST_SCAN;
            rr_q <= line_q + LW'(1);
          end else begin
            st_q <= ST_RD_CHAR;
          end
        end
        ST_RD_CHAR: if (hs) st_q <= ST_WR_PTR;
        ST_WR_PTR:  if (hs) st_q <= ST_WR_CNT;
        ST_WR_CNT: if (hs) begin
          st_q <= ST_SCAN;
          rr_q <= line_q + LW'(1);
        end
        default: st_q <= ST_SCAN;
      endcase
    end
  end

  // ---------------- active bits and interrupt ----------------------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      active_q <= (active_q & ~clr_vec) | act_set_i;
      irq_q    <= done | (irq_q & ~irq_clr_i);
    end
  end

  assign active_o = active_q;
  assign irq_o    = irq_q;

  // ---------------- per-line serializers ---------------------------------
  for (genvar g = 0; g < LINES; g++) begin : g_line
    txs_serializer #(.BIT_CLKS(BIT_CLKS)) u_ser (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (load_vec[g]),
      .data_i    (char_byte),
      .nbits_i   (nbits),
      .two_stop_i(two_stop_i),
      .brk_i     (brk_i[g]),
      .busy_o    (busy[g]),
      .line_o    (tx_line_o[g])
    );
  end
endmodule

// File: rtl/txs_scanner_chk.sv
module txs_scanner_chk #(
  parameter int unsigned LINES = 16,
  parameter int unsigned AW    = 16,
  parameter int unsigned DW    = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LINES-1:0] act_set_i,
  input logic [LINES-1:0] active_o,
  input logic [LINES-1:0] brk_i,
  input logic [LINES-1:0] tx_line_o,
  input logic             irq_o,
  input logic             irq_clr_i,
  input logic             mem_req_o,
  input logic             mem_we_o,
  input logic [AW-1:0]    mem_addr_o,
  input logic [DW-1:0]    mem_wdata_o,
  input logic             mem_ack_i
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) &&
                                $stable(mem_we_o) && $stable(mem_wdata_o)); // R6

  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_i & tx_line_o) == '0); // R8

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && !irq_clr_i |=> irq_o); // R9

  AST_ACTIVE_SET_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((active_o & ~$past(active_o) & ~$past(act_set_i)) == '0)); // R10

  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> !mem_addr_o[0]); // R2
endmodule

bind txs_scanner txs_scanner_chk #(.LINES(LINES), .AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .act_set_i  (act_set_i),
  .active_o   (active_o),
  .brk_i      (brk_i),
  .tx_line_o  (tx_line_o),
  .irq_o      (irq_o),
  .irq_clr_i  (irq_clr_i),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_wdata_o(mem_wdata_o),
  .mem_ack_i  (mem_ack_i)
);

// File: tb/txs_scanner_test.sv
`timescale 1ns/100ps
module txs_scanner_test;
  localparam int BC = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [7:0]  tab_base_i = 8'h12;
  logic [15:0] act_set_i = '0, active_o, brk_i = '0, tx_line_o;
  logic [1:0]  char_len_i = 2'd3;
  logic        two_stop_i = 1'b0, irq_o, irq_clr_i = 1'b0;
  logic        mem_req_o, mem_we_o, mem_ack_i = 1'b0;
  logic [15:0] mem_addr_o, mem_wdata_o, mem_rdata_i = '0;

  txs_scanner #(.BIT_CLKS(BC)) uut (.*);

  int checks = 0, errors = 0;
  bit finished = 0;
  int cfg_n = 8, cfg_s = 1;
  logic [15:0] rx_mute = '0;
  int got_q[$];
  int order_q[$];
  logic [15:0] mem [int];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] rd(logic [15:0] a);
    return mem.exists(int'(a >> 1)) ? mem[int'(a >> 1)] : 16'h0;
  endfunction

  // ---------- memory model and cycle-level service model ----------
  int cyc = 0, ph = 0, cur = 0;
  logic [15:0] lp [16];
  logic [15:0] lc [16];
  logic p_req = 0, p_ack = 0, p_we = 0;
  logic [15:0] p_addr = '0, p_wd = '0;

  always @(negedge clk) begin
    logic [15:0] tb, ea;
    bit ack;
    cyc++;
    tb  = {tab_base_i, 8'h00};
    ack = 0;
    if (rst_n && p_req && !p_ack)   // R6: held request unchanged
      chk(mem_req_o && mem_addr_o == p_addr && mem_we_o == p_we && mem_wdata_o == p_wd,
          "R6", "held request", int'(mem_addr_o), int'(p_addr));
    if (rst_n && brk_i != '0)       // R8
      chk((brk_i & tx_line_o) == '0, "R8", "break line", int'(tx_line_o), 0);
    if (rst_n && mem_req_o) begin
      ack = ((cyc * 7) % 5) != 0;
      if (ack) begin
        case (ph)
          0: begin
            cur = int'((mem_addr_o - tb) >> 1);
            chk(!mem_we_o && mem_addr_o >= tb && mem_addr_o < tb + 16'h20, "R2",
                "pointer read addr", int'(mem_addr_o), int'(tb));
            lp[cur & 15] = rd(mem_addr_o);
            order_q.push_back(cur);
            ph = 1;
          end
          1: begin
            ea = tb + 16'h20 + 16'(2 * cur);
            chk(!mem_we_o && mem_addr_o == ea, "R2", "count read addr", int'(mem_addr_o), int'(ea));
            lc[cur & 15] = rd(mem_addr_o);
            ph = (lc[cur & 15] == 0) ? 0 : 2;
          end
          2: begin
            ea = {lp[cur & 15][15:1], 1'b0};
            chk(!mem_we_o && mem_addr_o == ea, "R2", "char read addr", int'(mem_addr_o), int'(ea));
            ph = 3;
          end
          3: begin
            ea = tb + 16'(2 * cur);
            chk(mem_we_o && mem_addr_o == ea, "R3", "pointer write addr", int'(mem_addr_o), int'(ea));
            chk(mem_wdata_o == lp[cur & 15] + 16'd1, "R3", "pointer write data",
                int'(mem_wdata_o), int'(lp[cur & 15] + 16'd1));
            mem[int'(mem_addr_o >> 1)] = mem_wdata_o;
            ph = 4;
          end
          default: begin
            ea = tb + 16'h20 + 16'(2 * cur);
            chk(mem_we_o && mem_addr_o == ea, "R3", "count write addr", int'(mem_addr_o), int'(ea));
            chk(mem_wdata_o == lc[cur & 15] - 16'd1, "R3", "count write data",
                int'(mem_wdata_o), int'(lc[cur & 15] - 16'd1));
            mem[int'(mem_addr_o >> 1)] = mem_wdata_o;
            ph = 0;
          end
        endcase
      end
    end
    mem_ack_i   <= ack;
    mem_rdata_i <= rd(mem_addr_o);
    p_req = mem_req_o; p_ack = ack; p_we = mem_we_o;
    p_addr = mem_addr_o; p_wd = mem_wdata_o;
  end

  // ---------- mid-bit receivers, one per line (R7) ----------
  task automatic rx_line(int k);
    int v;
    forever begin
      @(negedge clk);
      if (rst_n && !rx_mute[k] && tx_line_o[k] == 1'b0) begin
        repeat (BC / 2) @(negedge clk);
        chk(tx_line_o[k] == 1'b0, "R7", "start bit", int'(tx_line_o[k]), 0);
        v = 0;
        for (int i = 0; i < cfg_n; i++) begin
          repeat (BC) @(negedge clk);
          v |= int'(tx_line_o[k]) << i;
        end
        for (int s = 0; s < cfg_s; s++) begin
          repeat (BC) @(negedge clk);
          chk(tx_line_o[k] == 1'b1, "R7", "stop bit", int'(tx_line_o[k]), 1);
        end
        got_q.push_back(k * 256 + v);
      end
    end
  endtask

  initial begin
    for (int k = 0; k < 16; k++) begin
      fork
        automatic int kk = k;
        rx_line(kk);
      join_none
    end
  end

  task automatic expect_chars(int k, int exp[$], string req);
    int seen[$];
    foreach (got_q[i]) if (got_q[i] / 256 == k) seen.push_back(got_q[i] % 256);
    chk(seen.size() == exp.size(), req, $sformatf("char count line %0d", k), seen.size(), exp.size());
    foreach (exp[i])
      if (i < seen.size())
        chk(seen[i] == exp[i], req, $sformatf("char %0d line %0d", i, k), seen[i], exp[i]);
  endtask

  task automatic wait_idle();
    int n = 0;
    while ((active_o != '0 || mem_req_o) && n < 20000) begin
      @(negedge clk); n++;
    end
    repeat (80) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // tables at 0x1200; line3 ptr 0x401 cnt 3, line5 cnt 0, line7 ptr 0x500 cnt 2, line12 ptr 0x601 cnt 1
    mem[int'(16'h1206 >> 1)] = 16'h0401; mem[int'(16'h1226 >> 1)] = 16'd3;
    mem[int'(16'h120A >> 1)] = 16'h0800; mem[int'(16'h122A >> 1)] = 16'd0;
    mem[int'(16'h120E >> 1)] = 16'h0500; mem[int'(16'h122E >> 1)] = 16'd2;
    mem[int'(16'h1218 >> 1)] = 16'h0601; mem[int'(16'h1238 >> 1)] = 16'd1;
    mem[int'(16'h0400 >> 1)] = 16'h4199; mem[int'(16'h0402 >> 1)] = 16'h4342;
    mem[int'(16'h0500 >> 1)] = 16'hAA55;
    mem[int'(16'h0600 >> 1)] = 16'h0F77;

    repeat (3) @(negedge clk);
    chk(active_o == '0, "R1", "active in reset", int'(active_o), 0);
    chk(tx_line_o == 16'hFFFF, "R1", "lines in reset", int'(tx_line_o), 16'hFFFF);
    chk(!mem_req_o && !irq_o, "R1", "req/irq in reset", int'({mem_req_o, irq_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(active_o == '0 && !mem_req_o && !irq_o && tx_line_o == 16'hFFFF, "R1",
        "after release", int'(active_o), 0);

    act_set_i = 16'h10A8;
    @(negedge clk);
    act_set_i = '0;
    chk(active_o == 16'h10A8, "R10", "active after pulse", int'(active_o), 16'h10A8);
    wait_idle();

    chk(order_q.size() >= 4, "R5", "services seen", order_q.size(), 4);
    if (order_q.size() >= 4) begin
      chk(order_q[0] == 3, "R5", "1st line", order_q[0], 3);
      chk(order_q[1] == 5, "R5", "2nd line", order_q[1], 5);
      chk(order_q[2] == 7, "R5", "3rd line", order_q[2], 7);
      chk(order_q[3] == 12, "R5", "4th line", order_q[3], 12);
    end
    expect_chars(3, '{8'h41, 8'h42, 8'h43}, "R2");
    expect_chars(7, '{8'h55, 8'hAA}, "R7");
    expect_chars(12, '{8'h0F}, "R2");
    expect_chars(5, '{}, "R4");
    chk(rd(16'h1206) == 16'h0404 && rd(16'h1226) == 16'd0, "R3", "line3 tables",
        int'(rd(16'h1206)), 16'h0404);
    chk(rd(16'h120E) == 16'h0502 && rd(16'h122E) == 16'd0, "R3", "line7 tables",
        int'(rd(16'h120E)), 16'h0502);
    chk(rd(16'h120A) == 16'h0800, "R4", "zero-count ptr untouched", int'(rd(16'h120A)), 16'h0800);
    chk(active_o == '0, "R4", "active cleared", int'(active_o), 0);
    chk(irq_o, "R4", "irq set", int'(irq_o), 1);

    repeat (5) @(negedge clk);
    chk(irq_o, "R9", "irq held", int'(irq_o), 1);
    irq_clr_i = 1'b1;
    @(negedge clk);
    irq_clr_i = 1'b0;
    chk(!irq_o, "R9", "irq cleared", int'(irq_o), 0);

    // 6 data bits, 2 stop bits on line 0
    char_len_i = 2'd1; two_stop_i = 1'b1; cfg_n = 6; cfg_s = 2;
    mem[int'(16'h1200 >> 1)] = 16'h0700; mem[int'(16'h1220 >> 1)] = 16'd2;
    mem[int'(16'h0700 >> 1)] = 16'hC5FF;
    act_set_i = 16'h0001;
    @(negedge clk);
    act_set_i = '0;
    wait_idle();
    expect_chars(0, '{8'h3F, 8'h05}, "R7");
    chk(irq_o, "R4", "irq after line 0", int'(irq_o), 1);

    // break on an idle line
    rx_mute[9] = 1'b1;
    brk_i[9] = 1'b1;
    repeat (10) @(negedge clk);
    chk(tx_line_o[9] == 1'b0, "R8", "line 9 held low", int'(tx_line_o[9]), 0);
    brk_i[9] = 1'b0;
    @(negedge clk);
    chk(tx_line_o[9] == 1'b1, "R8", "line 9 released", int'(tx_line_o[9]), 1);
    chk(active_o == '0, "R10", "no spurious active", int'(active_o), 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule